// File: doc/BRIEF.md
# Output Voltage Fault Supervisor

This block watches the digitized output-voltage sample of one regulated rail. Each valid sample is compared against a programmable overvoltage limit and a programmable undervoltage limit. If the sample leaves the window, the block runs a shutdown sequence. It drops the output-enable request, records the fault in a sticky status bit, raises an alert and pulls power-good low. For an overvoltage it also drives a toggling low-side switch request, which discharges the output until a sample falls back under the limit.

After a shutdown, the rail stays off until the enable input is taken low and then high again. When retry is switched on, the block instead waits a programmable number of cycles and then requests a restart by itself. The block also produces the power-good output. A mask chooses which fault sources (overvoltage, undervoltage, an external overcurrent flag) may hold power-good low. An open-sense input freezes supervision and forces the output off for as long as it is asserted.

Top module: `ovuv_supervisor`

## Requirements
- R1: A sample is taken only in a cycle with `sample_valid` high, and the compare result is held until the next valid sample. The sample counts as overvoltage when it is strictly above `ov_limit` and as undervoltage when it is strictly below `uv_limit`. It counts as in-window when `uv_limit <= sample <= ov_limit`, so both limits belong to the window.
- R2: The second rising edge after an overvoltage sample is accepted brings several changes together. `out_enable` goes low, `fault_ov` and `alert` go high, and `pg` goes low.
- R3: The low-side request `lsw_pulse` goes high at the same edge that sets `fault_ov`. It then alternates, staying high for `pulse_half` cycles and low for `pulse_half` cycles (a value of 0 behaves as 1), for as long as the held comparison shows overvoltage. It goes low at the second edge after an in-limit sample is accepted.
- R4: Undervoltage trips only while `ss_done` is high. It gives `out_enable` low, `fault_uv` high, `alert` high and `pg` low, and it never raises `lsw_pulse`.
- R5: With `retry_en` low, the output stays off after a fault until `enable` is low for at least one cycle. While `enable` is low, both fault bits are cleared. The output returns one cycle after `enable` goes high again.
- R6: With `retry_en` high, the block enters a wait once the fault is over: at once for undervoltage, or when the overvoltage clears. `out_enable` returns `retry_wait`+1 cycles after entering that wait.
- R7: `fault_ov` and `fault_uv` are sticky, and `alert` is high while either is set. A one-cycle `clear_faults` pulse clears both bits and `alert` without restarting the output.
- R8: `pg` is a registered output. It is high only when `enable` and `ss_done` are high, the held sample is in-window, `open_sense` is low, and no masked source is active.
- R9: `pg_mask` bit 0 lets `fault_ov` hold `pg` low, bit 1 lets `fault_uv` do so, and bit 2 lets `ocp_fault` do so. A source whose mask bit is 0 has no effect on `pg`.
- R10: While `open_sense` is high, `out_enable` and `lsw_pulse` are low. No fault is recorded, and the sequencer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Rail enable; a low pulse re-arms after a latched fault |
| ss_done | input | 1 | Soft-start complete |
| retry_en | input | 1 | Automatic restart after a fault |
| retry_wait | input | RW (16) | Restart delay in cycles |
| sample_valid | input | 1 | Sample strobe |
| sample | input | VW (12) | Output-voltage sample |
| ov_limit | input | VW (12) | Overvoltage limit |
| uv_limit | input | VW (12) | Undervoltage limit |
| pulse_half | input | PW (8) | Low-side request high/low time in cycles |
| ocp_fault | input | 1 | External overcurrent fault flag |
| open_sense | input | 1 | Voltage-sense path open |
| pg_mask | input | 3 | Power-good source mask (bit0 OV, bit1 UV, bit2 OC) |
| clear_faults | input | 1 | Clears the sticky fault bits |
| out_enable | output | 1 | Output stage run request |
| fault_ov | output | 1 | Sticky overvoltage fault |
| fault_uv | output | 1 | Sticky undervoltage fault |
| alert | output | 1 | Any fault recorded |
| lsw_pulse | output | 1 | Low-side switch request |
| pg | output | 1 | Power-good |

## Verification
The hardest state to reach is an automatic restart that is timed exactly while a fault bit is still set. Getting there takes an overvoltage that is first entered, then discharged through the pulse train, and then cleared by a new in-limit sample. Only after that can the retry counter run out. The stimulus builds this chain from directed sample steps and counts the cycles from the clearing sample. A seeded random phase runs alongside and sweeps in-window samples, including both limits, against random overcurrent and mask settings.

// File: rtl/ovuv_pkg.sv
// Shared definitions for the output-voltage supervisor.
// Assumes: three power-good sources in the fixed order OV, UV, OC.
package ovuv_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DISCH = 2'd2,
        ST_HOLD  = 2'd3
    } sup_state_t;

    localparam int PG_SRC_N  = 3;
    localparam int PG_SRC_OV = 0;
    localparam int PG_SRC_UV = 1;
    localparam int PG_SRC_OC = 2;
endpackage

// File: rtl/ovuv_compare.sv
// Window comparator: registers the overvoltage, undervoltage and in-window
// results of every valid sample and holds them between samples.
// Assumes: unsigned samples and limits of equal width.
module ovuv_compare #(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic [VW-1:0] sample,
    input  logic [VW-1:0] ov_limit,
    input  logic [VW-1:0] uv_limit,
    output logic          ov_now,
    output logic          uv_now,
    output logic          in_win
);
    // Capture the comparison results on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_now <= 1'b0;
            uv_now <= 1'b0;
            in_win <= 1'b0;
        end else if (sample_valid) begin
            ov_now <= sample > ov_limit;
            uv_now <= sample < uv_limit;
            in_win <= (sample <= ov_limit) && (sample >= uv_limit);
        end
    end
endmodule

// File: rtl/ovuv_seq.sv
// Fault sequencer: run/discharge/hold state machine, retry timer and the
// sticky fault bits.
// Assumes: comparator results are registered; enable low is a full re-arm.
module ovuv_seq
    import ovuv_pkg::*;
#(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          open_sense,
    input  logic          ss_done,
    input  logic          retry_en,
    input  logic [RW-1:0] retry_wait,
    input  logic          clear_faults,
    input  logic          ov_now,
    input  logic          uv_now,
    output sup_state_t    state,
    output logic          start_disch,
    output logic          fault_ov,
    output logic          fault_uv
);
    sup_state_t    nxt;
    logic [RW-1:0] wcnt;
    logic          set_uv;

    // Next-state decision; frozen while the sense path is open.
    always_comb begin
        nxt         = state;
        start_disch = 1'b0;
        set_uv      = 1'b0;
        if (!enable) begin
            nxt = ST_OFF;
        end else if (!open_sense) begin
            case (state)
                ST_OFF:   nxt = ST_RUN;
                ST_RUN: begin
                    if (ov_now) begin
                        nxt         = ST_DISCH;
                        start_disch = 1'b1;
                    end else if (uv_now && ss_done) begin
                        nxt    = ST_HOLD;
                        set_uv = 1'b1;
                    end
                end
                ST_DISCH: if (!ov_now) nxt = ST_HOLD;
                ST_HOLD:  if (retry_en && (wcnt >= retry_wait)) nxt = ST_RUN;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Retry timer: counts cycles spent in hold, restarts on every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (state == ST_HOLD && nxt == ST_HOLD) begin
            if (retry_en && !open_sense && wcnt != '1) wcnt <= wcnt + 1'b1;
        end else begin
            wcnt <= '0;
        end
    end

    // Sticky fault bits: set on trip, cleared by strobe or enable low.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            fault_ov <= 1'b0;
            fault_uv <= 1'b0;
        end else begin
            fault_ov <= start_disch | (fault_ov & ~clear_faults);
            fault_uv <= set_uv      | (fault_uv & ~clear_faults);
        end
    end
endmodule

// File: rtl/ovuv_pulse.sv
// Low-side request generator: a square wave with equal high and low times,
// started high on entry to discharge, stopped when discharge ends.
// Assumes: a half period of zero is treated as one cycle.
module ovuv_pulse #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          hold,
    input  logic [PW-1:0] half,
    output logic          lsw
);
    logic [PW-1:0] half_eff;
    logic [PW-1:0] pcnt;

    // Clamp the half period to at least one cycle.
    assign half_eff = (half == '0) ? PW'(1) : half;

    // Phase counter and output toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsw  <= 1'b0;
            pcnt <= '0;
        end else if (start) begin
            lsw  <= 1'b1;
            pcnt <= PW'(1);
        end else if (hold) begin
            if (pcnt >= half_eff) begin
                lsw  <= ~lsw;
                pcnt <= PW'(1);
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end else begin
            lsw  <= 1'b0;
            pcnt <= '0;
        end
    end
endmodule

// File: rtl/ovuv_pg.sv
// Power-good qualifier: combines soft-start, window and open-sense status
// with the masked fault sources into one registered output.
// Assumes: one mask bit per source, same order as the source vector.
module ovuv_pg #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            ss_done,
    input  logic            in_win,
    input  logic            open_sense,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] mask,
    output logic            pg
);
    logic [NSRC-1:0] blocked;

    // One gate per source: only masked-in sources may block power-good.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign blocked[i] = src[i] & mask[i];
    end

    // Register the qualified power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) pg <= 1'b0;
        else        pg <= enable && ss_done && in_win && !open_sense && !(|blocked);
    end
endmodule

// File: rtl/ovuv_supervisor.sv
// Output-voltage fault supervisor top: window compare, fault sequencing,
// low-side discharge pulses and power-good for one rail.
// Assumes: sample, limits and configuration are synchronous to clk.
module ovuv_supervisor
    import ovuv_pkg::*;
#(
    parameter int VW = 12,
    parameter int RW = 16,
    parameter int PW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                ss_done,
    input  logic                retry_en,
    input  logic [RW-1:0]       retry_wait,
    input  logic                sample_valid,
    input  logic [VW-1:0]       sample,
    input  logic [VW-1:0]       ov_limit,
    input  logic [VW-1:0]       uv_limit,
    input  logic [PW-1:0]       pulse_half,
    input  logic                ocp_fault,
    input  logic                open_sense,
    input  logic [PG_SRC_N-1:0] pg_mask,
    input  logic                clear_faults,
    output logic                out_enable,
    output logic                fault_ov,
    output logic                fault_uv,
    output logic                alert,
    output logic                lsw_pulse,
    output logic                pg
);
    logic          ov_now, uv_now, in_win;
    sup_state_t    state;
    logic          start_disch;
    logic          lsw_q;
    logic [PG_SRC_N-1:0] pg_src;

    ovuv_compare #(.VW(VW)) i_cmp (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
        .ov_limit(ov_limit), .uv_limit(uv_limit),
        .ov_now(ov_now), .uv_now(uv_now), .in_win(in_win)
    );

    ovuv_seq #(.RW(RW)) i_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .open_sense(open_sense),
        .ss_done(ss_done), .retry_en(retry_en), .retry_wait(retry_wait),
        .clear_faults(clear_faults), .ov_now(ov_now), .uv_now(uv_now),
        .state(state), .start_disch(start_disch),
        .fault_ov(fault_ov), .fault_uv(fault_uv)
    );

    ovuv_pulse #(.PW(PW)) i_pulse (
        .clk(clk), .rst_n(rst_n), .start(start_disch),
        .hold((state == ST_DISCH) && ov_now), .half(pulse_half), .lsw(lsw_q)
    );

    // Fault sources in package order for the power-good mask.
    assign pg_src[PG_SRC_OV] = fault_ov;
    assign pg_src[PG_SRC_UV] = fault_uv;
    assign pg_src[PG_SRC_OC] = ocp_fault;

    ovuv_pg #(.NSRC(PG_SRC_N)) i_pg (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
        .in_win(in_win), .open_sense(open_sense), .src(pg_src),
        .mask(pg_mask), .pg(pg)
    );

    // Output drive, gated off while the sense path is open.
    assign out_enable = (state == ST_RUN) && !open_sense;
    assign lsw_pulse  = lsw_q && !open_sense;
    assign alert      = fault_ov | fault_uv;
endmodule

// File: rtl/ovuv_supervisor_chk.sv
// Property checker for the output-voltage supervisor, bound to the top.
// Assumes: observes top-level ports only.
module ovuv_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ss_done,
    input logic open_sense,
    input logic clear_faults,
    input logic out_enable,
    input logic fault_ov,
    input logic fault_uv,
    input logic lsw_pulse,
    input logic pg
);
    // R2: an overvoltage trip comes with output off and power-good low.
    a_r2_trip_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_ov) |-> (!out_enable && !pg));

    // R3: discharge pulses only occur while the output is off.
    a_r3_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        lsw_pulse |-> !out_enable);

    // R4: undervoltage is only recorded after soft-start.
    a_r4_uv_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_uv) |-> $past(ss_done));

    // R7: the overvoltage bit holds without a clear or enable drop.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ov && enable && !clear_faults) |=> fault_ov);

    // R8: no power-good without soft-start complete.
    a_r8_pg_needs_ss: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> !pg);

    // R10: an open sense path freezes the fault record.
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (open_sense && enable && !clear_faults) |=> ($stable(fault_ov) && $stable(fault_uv)));
endmodule

bind ovuv_supervisor ovuv_supervisor_chk i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
    .open_sense(open_sense), .clear_faults(clear_faults),
    .out_enable(out_enable), .fault_ov(fault_ov), .fault_uv(fault_uv),
    .lsw_pulse(lsw_pulse), .pg(pg)
);

// File: tb/test_ovuv_supervisor.sv
module test_ovuv_supervisor;
    localparam int VW = 12;
    localparam int RW = 16;
    localparam int PW = 8;
    localparam int OVL = 3000;
    localparam int UVL = 1000;

    logic clk = 1'b0;
    logic rst_n, enable, ss_done, retry_en, sample_valid, ocp_fault, open_sense, clear_faults;
    logic [RW-1:0] retry_wait;
    logic [VW-1:0] sample, ov_limit, uv_limit;
    logic [PW-1:0] pulse_half;
    logic [2:0]    pg_mask;
    logic out_enable, fault_ov, fault_uv, alert, lsw_pulse, pg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ovuv_supervisor i_ovuv_supervisor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
        .retry_en(retry_en), .retry_wait(retry_wait), .sample_valid(sample_valid),
        .sample(sample), .ov_limit(ov_limit), .uv_limit(uv_limit),
        .pulse_half(pulse_half), .ocp_fault(ocp_fault), .open_sense(open_sense),
        .pg_mask(pg_mask), .clear_faults(clear_faults), .out_enable(out_enable),
        .fault_ov(fault_ov), .fault_uv(fault_uv), .alert(alert),
        .lsw_pulse(lsw_pulse), .pg(pg)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected in-window flag (R1).
    function automatic bit f_in_win(int s);
        return (s >= UVL) && (s <= OVL);
    endfunction

    // Expected power-good while running with no fault bits (R8, R9).
    function automatic bit f_pg(int s, bit ocp, bit m_oc);
        return f_in_win(s) && !(ocp && m_oc);
    endfunction

    task automatic apply_sample(input int s);
        @(negedge clk);
        sample = VW'(s);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7341));
        rst_n = 0; enable = 0; ss_done = 0; retry_en = 0; sample_valid = 0;
        ocp_fault = 0; open_sense = 0; clear_faults = 0; retry_wait = 16'd20;
        sample = '0; ov_limit = VW'(OVL); uv_limit = VW'(UVL);
        pulse_half = 8'd3; pg_mask = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        chk("R8 reset pg", pg, 0);
        chk("R5 reset out_enable", out_enable, 0);
        chk("R7 reset alert", alert, 0);
        chk("R3 reset lsw", lsw_pulse, 0);

        enable = 1;
        settle();
        chk("R5 enable starts output", out_enable, 1);

        // R4: low sample before soft-start does not trip
        apply_sample(100);
        settle();
        chk("R4 uv ignored before ss_done", fault_uv, 0);
        chk("R4 output stays on", out_enable, 1);
        chk("R8 pg low before ss_done", pg, 0);

        apply_sample(2000);
        settle();
        ss_done = 1;
        settle();
        chk("R8 pg high in window", pg, 1);

        // R1 boundaries belong to the window
        apply_sample(OVL);
        settle();
        chk("R1 ov_limit in window", pg, 1);
        chk("R1 ov_limit no trip", fault_ov, 0);
        apply_sample(UVL);
        settle();
        chk("R1 uv_limit in window", pg, 1);
        chk("R1 uv_limit no trip", fault_uv, 0);

        // Random in-window sweep with overcurrent and its mask (R1, R8, R9)
        for (int i = 0; i < 300; i++) begin
            int  s;
            bit  ocp, moc;
            s   = UVL + int'($urandom % (OVL - UVL + 1));
            ocp = 1'($urandom % 2);
            moc = 1'($urandom % 2);
            @(negedge clk);
            ocp_fault = ocp;
            pg_mask = {moc, 2'b11};
            sample = VW'(s);
            sample_valid = 1'b1;
            @(negedge clk);
            sample_valid = 1'b0;
            settle();
            chk("R9 random pg vs oc mask", pg, int'(f_pg(s, ocp, moc)));
            chk("R1 random no fault", int'(alert), 0);
        end
        ocp_fault = 0;
        pg_mask = 3'b111;

        // R2/R3: overvoltage trip and pulse train
        apply_sample(OVL + 1);
        settle();
        chk("R2 fault_ov set", fault_ov, 1);
        chk("R2 alert set", alert, 1);
        chk("R2 output off", out_enable, 0);
        chk("R2 pg low", pg, 0);
        chk("R3 lsw starts high", lsw_pulse, 1);
        for (int i = 1; i < 12; i++) begin
            settle();
            chk("R3 lsw pattern", lsw_pulse, ((i / 3) % 2 == 0) ? 1 : 0);
        end
        apply_sample(2000);
        settle();
        chk("R3 lsw stops after recovery", lsw_pulse, 0);
        chk("R7 fault_ov sticky", fault_ov, 1);
        repeat (30) @(negedge clk);
        chk("R5 latched off without retry", out_enable, 0);

        // R7: clear strobe
        @(negedge clk);
        clear_faults = 1;
        @(negedge clk);
        clear_faults = 0;
        chk("R7 clear drops fault_ov", fault_ov, 0);
        chk("R7 clear drops alert", alert, 0);
        chk("R7 clear does not restart", out_enable, 0);

        // R5: enable cycle restarts
        enable = 0;
        settle();
        enable = 1;
        settle();
        chk("R5 enable cycle restarts", out_enable, 1);

        // R4: undervoltage trip after soft-start
        apply_sample(500);
        settle();
        chk("R4 fault_uv set", fault_uv, 1);
        chk("R4 no ov bit", fault_ov, 0);
        chk("R4 output off", out_enable, 0);
        chk("R4 no lsw", lsw_pulse, 0);
        chk("R4 pg low", pg, 0);
        chk("R7 alert on uv", alert, 1);

        // R9: UV mask bit
        pg_mask = 3'b101;
        apply_sample(2000);
        settle();
        chk("R9 uv unmasked pg high", pg, 1);
        chk("R5 still latched", out_enable, 0);
        pg_mask = 3'b111;
        settle();
        chk("R9 uv masked pg low", pg, 0);

        // R5: enable low clears bits
        enable = 0;
        settle();
        chk("R5 enable low clears fault_uv", fault_uv, 0);
        enable = 1;
        settle();

        // R6: retry after undervoltage, retry_wait = 20
        retry_en = 1;
        retry_wait = 16'd20;
        apply_sample(500);
        settle();
        chk("R6 uv trip before retry", out_enable, 0);
        apply_sample(2000);
        for (int k = 3; k <= 20; k++) begin
            settle();
            chk("R6 waiting", out_enable, 0);
        end
        settle();
        chk("R6 restart after wait", out_enable, 1);
        chk("R7 fault_uv sticky across retry", fault_uv, 1);

        // R6: retry after overvoltage clears, retry_wait = 5
        retry_wait = 16'd5;
        apply_sample(OVL + 50);
        settle();
        chk("R6 ov trip", fault_ov, 1);
        apply_sample(2000);
        settle();
        for (int k = 1; k <= 5; k++) begin
            settle();
            chk("R6 ov waiting", out_enable, 0);
        end
        settle();
        chk("R6 ov restart", out_enable, 1);

        // R10: open sense
        @(negedge clk);
        clear_faults = 1;
        @(negedge clk);
        clear_faults = 0;
        settle();
        chk("R8 pg back before open", pg, 1);
        open_sense = 1;
        settle();
        chk("R10 output off", out_enable, 0);
        chk("R10 pg low", pg, 0);
        apply_sample(OVL + 200);
        settle();
        chk("R10 no fault while open", fault_ov, 0);
        chk("R10 no lsw while open", lsw_pulse, 0);
        apply_sample(2000);
        settle();
        open_sense = 0;
        settle();
        chk("R10 resume output", out_enable, 1);
        chk("R10 no fault after resume", fault_ov, 0);
        settle();
        chk("R10 pg after resume", pg, 1);

        ss_done = 0;
        settle();
        chk("R8 pg drops with ss_done", pg, 0);

        finish_run();
    end
endmodule